// File: doc/BRIEF.md
# Partial-Word Store Lane Generator

This block turns a "store bytes" request into a single aligned write on a big-endian word-wide memory port. A request carries a byte address, a register value and a variant select, either begin or end. The two low address bits, taken as the offset inside the word, decide which register bytes are stored. In the begin variant the bytes run from the addressed byte to the end of the word. In the end variant they run from the start of the word up to, but not including, the addressed byte.

Each accepted request produces exactly one write beat. That beat has a word-aligned address, a byte-enable mask and lane-aligned data. Because every store, three-byte stores included, leaves as one beat, the memory sees it as indivisible. An end-variant request at offset zero writes no bytes. It still issues a beat, with an all-zero mask and the probe flag raised, so that downstream logic can do its permission check and dirty marking.

Both sides use a valid/ready handshake. One output register sits between them, and new requests are accepted only when that register is empty or is being drained in the same cycle.

Top module: `store_lane_gen`

## Requirements
- R1: Begin variant, offset 0: mask 4'b1111 and the full register value as data. Mask bit k covers data bits 8k+7:8k, and byte lane 0 (lowest address) is bits 31:24.
- R2: Begin variant, offset 1: mask 4'b0111, with register bits 23:0 on data bits 23:0 and zeros in the unwritten lane.
- R3: Begin variant, offset 2: mask 4'b0011, with register bits 15:0 on data bits 15:0 and zeros elsewhere.
- R4: Begin variant, offset 3: mask 4'b0001, with register bits 7:0 on data bits 7:0 and zeros elsewhere.
- R5: End variant, offset 3: mask 4'b1110, with register bits 31:8 on data bits 31:8 and zeros in bits 7:0.
- R6: End variant, offset 2: mask 4'b1100, with register bits 31:16 on data bits 31:16 and zeros elsewhere.
- R7: End variant, offset 1: mask 4'b1000, with register bits 31:24 on data bits 31:24 and zeros elsewhere.
- R8: End variant, offset 0: a beat is still issued, with mask 4'b0000, data zero and the probe flag high. Every other case has the probe flag low.
- R9: The output address equals the request address with its two low bits cleared.
- R10: While the output is valid and not accepted, the output beat holds stable and request ready is low.
- R11: During reset and after its release, the output valid is low and request ready is high.
- R12: A request is accepted when its valid and ready are both high. Its beat appears one cycle later, and exactly one beat is issued per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Register value to store |
| req_end | input | 1 | Variant: 0 begin, 1 end |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory port takes the beat |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_be | output | DATA_W/8 | Byte enables, bit k covers data bits 8k+7:8k |
| wr_data | output | DATA_W | Lane-aligned write data |
| wr_probe | output | 1 | No bytes written, access is a probe |

## Verification
If the lane decode is wrong, a wrong mask bit or a stale byte appears on the very next beat, one cycle after acceptance. Every variant and offset pair is therefore compared directly against the mask and the data. If the output register or handshake state is corrupted, the effect shows at the port: a second beat is issued for a single request, or data changes under backpressure. The bench catches both by checking valid one cycle after the drain and by holding ready low for several cycles.

// File: rtl/slg_pkg.sv
package slg_pkg;
  typedef enum logic {
    VAR_BEGIN = 1'b0,
    VAR_END   = 1'b1
  } store_var_e;
endpackage

// File: rtl/slg_lane_decode.sv
module slg_lane_decode
  import slg_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  store_var_e       variant,
  input  logic [OFF_W-1:0] offset,
  output logic [LANES-1:0] be,
  output logic             probe
);
  // Mask bit k serves lane LANES-1-k (big-endian: lane 0 is the MSB byte).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LANE = LANES - 1 - k;
    always_comb begin
      if (variant == VAR_END) be[k] = (OFF_W'(LANE) < offset);
      else                    be[k] = (OFF_W'(LANE) >= offset);
    end
  end

  always_comb probe = (variant == VAR_END) && (offset == '0);
endmodule

// File: rtl/slg_data_steer.sv
module slg_data_steer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] data
);
  // Register bytes keep their position; unwritten lanes are driven to zero.
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    always_comb data[8*k +: 8] = be[k] ? value[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/slg_out_stage.sv
module slg_out_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_probe,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_be,
  output logic [DATA_W-1:0] out_data,
  output logic              out_probe
);
  logic              valid_q, valid_d;
  logic              load;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] data_q;
  logic              probe_q;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load     = in_valid && in_ready;
    valid_d  = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
      probe_q <= 1'b0;
    end else if (load) begin
      addr_q  <= in_addr;
      be_q    <= in_be;
      data_q  <= in_data;
      probe_q <= in_probe;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_be    = be_q;
  assign out_data  = data_q;
  assign out_probe = probe_q;

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
                                && $stable(out_data) && $stable(out_probe));
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r12_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r12_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
  import slg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_end,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_probe
);
  store_var_e        variant;
  logic [OFF_W-1:0]  offset;
  logic [LANES-1:0]  be_c;
  logic              probe_c;
  logic [DATA_W-1:0] data_c;
  logic [ADDR_W-1:0] addr_c;

  assign variant = store_var_e'(req_end);
  assign offset  = req_addr[OFF_W-1:0];
  assign addr_c  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  slg_lane_decode #(.LANES(LANES)) u_decode (
    .variant (variant),
    .offset  (offset),
    .be      (be_c),
    .probe   (probe_c)
  );

  slg_data_steer #(.DATA_W(DATA_W)) u_steer (
    .value (req_data),
    .be    (be_c),
    .data  (data_c)
  );

  slg_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (addr_c),
    .in_be     (be_c),
    .in_data   (data_c),
    .in_probe  (probe_c),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_addr  (wr_addr),
    .out_be    (wr_be),
    .out_data  (wr_data),
    .out_probe (wr_probe)
  );

  a_r8_probe_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_probe |-> wr_be == '0 && wr_data == '0);
  a_r8_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_probe |-> wr_be != '0);
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> wr_addr[OFF_W-1:0] == '0);
  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> req_ready);
endmodule

// File: tb/store_lane_gen_bench.sv
module store_lane_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_end, wr_ready;
  logic [31:0] req_addr, req_data;
  logic        req_ready, wr_valid, wr_probe;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_lane_gen u_store_lane_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_end(req_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
  );

  // {is_end, addr, value, exp_be, exp_data, exp_probe}
  localparam logic [101:0] VEC [16] = '{
    {1'b0, 32'h1000_0000, 32'hA1B2C3D4, 4'b1111, 32'hA1B2C3D4, 1'b0}, // R1
    {1'b0, 32'h1000_0001, 32'hA1B2C3D4, 4'b0111, 32'h00B2C3D4, 1'b0}, // R2
    {1'b0, 32'h1000_0002, 32'hA1B2C3D4, 4'b0011, 32'h0000C3D4, 1'b0}, // R3
    {1'b0, 32'h1000_0003, 32'hA1B2C3D4, 4'b0001, 32'h000000D4, 1'b0}, // R4
    {1'b1, 32'h1000_0003, 32'hA1B2C3D4, 4'b1110, 32'hA1B2C300, 1'b0}, // R5
    {1'b1, 32'h1000_0002, 32'hA1B2C3D4, 4'b1100, 32'hA1B20000, 1'b0}, // R6
    {1'b1, 32'h1000_0001, 32'hA1B2C3D4, 4'b1000, 32'hA1000000, 1'b0}, // R7
    {1'b1, 32'h1000_0000, 32'hA1B2C3D4, 4'b0000, 32'h00000000, 1'b1}, // R8
    {1'b0, 32'hFFFF_FFFC, 32'h5E6F7081, 4'b1111, 32'h5E6F7081, 1'b0}, // R1
    {1'b0, 32'h0000_0C05, 32'h5E6F7081, 4'b0111, 32'h006F7081, 1'b0}, // R2
    {1'b0, 32'h8765_432A, 32'h5E6F7081, 4'b0011, 32'h00007081, 1'b0}, // R3
    {1'b0, 32'hFFFF_FFFF, 32'h5E6F7081, 4'b0001, 32'h00000081, 1'b0}, // R4
    {1'b1, 32'h0000_0007, 32'h5E6F7081, 4'b1110, 32'h5E6F7000, 1'b0}, // R5
    {1'b1, 32'h7FFF_FFFE, 32'h5E6F7081, 4'b1100, 32'h5E6F0000, 1'b0}, // R6
    {1'b1, 32'hDEAD_BEE5, 32'h5E6F7081, 4'b1000, 32'h5E000000, 1'b0}, // R7
    {1'b1, 32'h0000_0004, 32'h5E6F7081, 4'b0000, 32'h00000000, 1'b1}  // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_beat(input logic [31:0] a, input logic [3:0] be,
                            input logic [31:0] d, input logic p, input string req);
    chk(wr_valid === 1'b1, "R12 beat valid", 32'(wr_valid), 32'h1);
    chk(wr_be === be, req, 32'(wr_be), 32'(be));
    chk(wr_data === d, req, wr_data, d);
    chk(wr_probe === p, "R8 probe flag", 32'(wr_probe), 32'(p));
    chk(wr_addr === (a & 32'hFFFF_FFFC), "R9 aligned address", wr_addr,
        a & 32'hFFFF_FFFC);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_end = 1'b0; wr_ready = 1'b1;
    req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    chk(wr_valid === 1'b0, "R11 valid low in reset", 32'(wr_valid), 32'h0);
    chk(req_ready === 1'b1, "R11 ready high in reset", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid === 1'b0, "R11 valid low after reset", 32'(wr_valid), 32'h0);

    // Table walk: one request, one beat, then drain.
    for (int i = 0; i < 16; i++) begin
      logic [101:0] v;
      v = VEC[i];
      req_end = v[101]; req_addr = v[100:69]; req_data = v[68:37];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_beat(v[100:69], v[36:33], v[32:1], v[0],
                 $sformatf("R1-8 lanes vector %0d", i));
      @(negedge clk);
      chk(wr_valid === 1'b0, "R12 single beat", 32'(wr_valid), 32'h0);
    end

    // R10: backpressure holds the beat and blocks a second request.
    wr_ready = 1'b0;
    req_end = 1'b0; req_addr = 32'h2000_0001; req_data = 32'hCAFE_F00D;
    req_valid = 1'b1;
    @(negedge clk);
    req_end = 1'b1; req_addr = 32'h3000_0002; req_data = 32'h1357_9BDF;
    for (int c = 0; c < 4; c++) begin
      check_beat(32'h2000_0001, 4'b0111, 32'h00FE_F00D, 1'b0, "R10 held beat");
      chk(req_ready === 1'b0, "R10 ready low while stalled", 32'(req_ready), 32'h0);
      @(negedge clk);
    end
    wr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(32'h3000_0002, 4'b1100, 32'h1357_0000, 1'b0, "R6 back-to-back beat");
    @(negedge clk);
    chk(wr_valid === 1'b0, "R12 drained after pair", 32'(wr_valid), 32'h0);

    // R8 under backpressure: probe beat is held too.
    wr_ready = 1'b0;
    req_end = 1'b1; req_addr = 32'h4000_0010; req_data = 32'hFFFF_FFFF;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_beat(32'h4000_0010, 4'b0000, 32'h0, 1'b1, "R8 held probe");
    wr_ready = 1'b1;
    @(negedge clk);
    chk(wr_valid === 1'b0, "R12 probe single beat", 32'(wr_valid), 32'h0);

    // R11: reset in the middle of a held beat clears it.
    wr_ready = 1'b0; req_end = 1'b0; req_addr = 32'h10; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(wr_valid === 1'b0, "R11 reset clears beat", 32'(wr_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1; wr_ready = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready after reset", 32'(req_ready), 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule